// File: doc/BRIEF.md
# Two-Phase Accumulating Adder

This block keeps an accumulator register and adds a bus value into it in two steps, each started by its own external strobe. The first strobe folds the bus into the accumulator bit by bit, leaving the carry-less sum there, and records in a side register which bit positions generated a carry. The second strobe resolves those recorded carries into the final two's complement sum. The carry-out of the top bit is kept in a flag.

Carry resolution works on groups of bits. A group holds `GRP` bits, and one group is resolved per clock, starting with the lowest group. The ripple from one group into the next takes the extra cycles. A group as wide as the register gives a one-cycle second phase. Narrower groups use less carry logic per cycle and need `W/GRP` cycles.

The accumulator can also be cleared. It can be loaded from the bus in two cycles: the first cycle zeroes it, and the second sets the bits that are one on the bus.

Top module: `twophase_acc`

## Requirements
- R1: After reset the accumulator is 0 and both `carry_out` and `done` are 0.
- R2: When idle, not armed, and no clear or load is present, a phase-one strobe replaces `acc` with `acc XOR bus_z` at the next edge and arms the block. The same edge clears `done` and `carry_out`.
- R3: A phase-two strobe while armed (no clear, load or phase-one present) resolves carries. After `W/GRP` clock edges, counted from and including the strobe edge, `{carry_out, acc}` equals the original accumulator value plus the bus value, and `done` goes to 1 on that same edge.
- R4: Carries are resolved one group of `GRP` bits per cycle, lowest group first. The carry leaving a group enters the next group on the following cycle.
- R5: A phase-two strobe while not armed is ignored: `acc` keeps its value and `done` stays 0.
- R6: A phase-one strobe while already armed is ignored, so the final sum still uses only the first bus value.
- R7: A clear strobe while idle sets `acc` to 0, disarms the block and clears `done` and `carry_out`. Clear has the highest priority, then load, then phase one, then phase two.
- R8: A load strobe zeroes `acc` at its edge. On the following edge it ORs the bus into `acc`, so with the bus held for both cycles `acc` equals the bus value.
- R9: While a carry resolution is in progress, and during the second cycle of a load, all strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_z | input | W | Operand / load bus |
| ph1_stb | input | 1 | Phase-one strobe (partial sum and carry capture) |
| ph2_stb | input | 1 | Phase-two strobe (carry resolution) |
| clr_stb | input | 1 | Clear accumulator |
| load_stb | input | 1 | Load accumulator from bus |
| acc | output | W | Accumulator value |
| carry_out | output | 1 | Carry out of the top bit from the last addition |
| done | output | 1 | Carry resolution finished |

## Verification
The operand pairs are chosen so that each one tells apart a different carry behaviour:
- Zero plus zero and complementary patterns generate no carries at all.
- An all-ones value plus one sends a single carry across every group boundary.
- Two top-bit-only operands produce only a carry-out.
- Two all-ones operands generate carries at every bit.

Each pair is run through a one-group instance and a four-group instance. Both the partial sum after phase one and the number of cycles before `done` are compared, so that an adder folded into a single phase, or carries crossing groups out of order, produce a mismatch.

// File: rtl/twophase_acc.sv
module twophase_acc #(
  parameter int W   = 4,
  parameter int GRP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_z,
  input  logic         ph1_stb,
  input  logic         ph2_stb,
  input  logic         clr_stb,
  input  logic         load_stb,
  output logic [W-1:0] acc,
  output logic         carry_out,
  output logic         done
);
  localparam int NG = W / GRP;
  localparam int GW = (NG > 1) ? $clog2(NG) : 1;

  logic [W-1:0]  gen;
  logic          armed, busy, ldset, cin;
  logic [GW-1:0] gidx;

  wire idle    = !busy && !ldset;
  wire take_cl = idle && clr_stb;
  wire take_ld = idle && !clr_stb && load_stb;
  wire take_p1 = idle && !clr_stb && !load_stb && ph1_stb && !armed;
  wire take_p2 = idle && !clr_stb && !load_stb && !ph1_stb && ph2_stb && armed;
  wire step    = busy || take_p2;

  wire [GW-1:0] grp  = busy ? gidx : '0;
  wire          last = (grp == GW'(NG - 1));

  logic [W-1:0] nxt_acc;
  logic         nxt_c;

  always_comb begin
    logic c;
    c       = busy ? cin : 1'b0;
    nxt_acc = acc;
    for (int i = 0; i < W; i++) begin
      if (i / GRP == int'(grp)) begin
        nxt_acc[i] = acc[i] ^ c;
        c          = gen[i] | (acc[i] & c);
      end
    end
    nxt_c = c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      gen       <= '0;
      armed     <= 1'b0;
      busy      <= 1'b0;
      ldset     <= 1'b0;
      cin       <= 1'b0;
      gidx      <= '0;
      carry_out <= 1'b0;
      done      <= 1'b0;
    end else if (step) begin
      acc <= nxt_acc;
      cin <= nxt_c;
      if (last) begin
        busy      <= 1'b0;
        armed     <= 1'b0;
        done      <= 1'b1;
        carry_out <= nxt_c;
        gidx      <= '0;
      end else begin
        busy <= 1'b1;
        gidx <= grp + 1'b1;
      end
    end else if (ldset) begin
      acc   <= acc | bus_z;
      ldset <= 1'b0;
    end else if (take_cl || take_ld) begin
      acc       <= '0;
      armed     <= 1'b0;
      done      <= 1'b0;
      carry_out <= 1'b0;
      ldset     <= take_ld;
    end else if (take_p1) begin
      acc       <= acc ^ bus_z;
      gen       <= acc & bus_z;
      armed     <= 1'b1;
      done      <= 1'b0;
      carry_out <= 1'b0;
    end
  end

  // R3
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy || ph2_stb));

  // R5
  p2_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !armed && ph2_stb && !ph1_stb && !clr_stb && !load_stb) |=> ($stable(acc) && !done));

  // R6
  p1_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && armed && ph1_stb && !ph2_stb && !clr_stb && !load_stb) |=> $stable(acc));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && clr_stb) |=> (acc == '0 && !done && !carry_out));

  // R8
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !clr_stb && load_stb) |=> (acc == '0) ##1 (acc == $past(bus_z)));

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ph2_stb && armed));
endmodule

// File: tb/tb_twophase_acc.sv
module tb_twophase_acc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] z4 = '0;
  logic [7:0] z8 = '0;
  logic ph1 = 0, ph2 = 0, clr = 0, ld = 0;
  logic [3:0] acc4;
  logic [7:0] acc8;
  logic co4, co8, dn4, dn8;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  twophase_acc #(.W(4), .GRP(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_z(z4), .ph1_stb(ph1), .ph2_stb(ph2),
    .clr_stb(clr), .load_stb(ld), .acc(acc4), .carry_out(co4), .done(dn4));

  twophase_acc #(.W(8), .GRP(2)) dut_g (
    .clk(clk), .rst_n(rst_n), .bus_z(z8), .ph1_stb(ph1), .ph2_stb(ph2),
    .clr_stb(clr), .load_stb(ld), .acc(acc8), .carry_out(co8), .done(dn8));

  localparam logic [15:0] VEC [8] = '{
    16'h0000, 16'hFF01, 16'h0F01, 16'h55AA,
    16'h8080, 16'h7F7F, 16'h3C0C, 16'hFFFF};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic load(logic [7:0] v);
    z8 = v; z4 = v[3:0];
    pulse(ld);
    @(negedge clk);
  endtask

  task automatic resolve(output int cyc);
    ph2 = 1'b1;
    cyc = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      ph2 = 1'b0;
      if (dn8) break;
    end
  endtask

  task automatic run_add(logic [7:0] a, logic [7:0] b);
    int cyc;
    logic [8:0] s8;
    logic [4:0] s4;
    s8 = {1'b0, a} + {1'b0, b};
    s4 = {1'b0, a[3:0]} + {1'b0, b[3:0]};
    load(a);
    z8 = b; z4 = b[3:0];
    pulse(ph1);
    check("R2 partial4", acc4, a[3:0] ^ b[3:0]);
    check("R2 partial8", acc8, a ^ b);
    resolve(cyc);
    check("R3 sum4", {co4, acc4}, s4);
    check("R3 done4", dn4, 1);
    check("R3 sum8", {co8, acc8}, s8);
    check("R4 cycles8", cyc, 4);
  endtask

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    check("R1 acc4", acc4, 0);
    check("R1 acc8", acc8, 0);
    check("R1 flags", {co4, dn4, co8, dn8}, 0);

    for (int i = 0; i < 8; i++) run_add(VEC[i][15:8], VEC[i][7:0]);

    // R7 clear
    pulse(clr);
    check("R7 clear acc", acc8, 0);
    check("R7 clear flags", {co8, dn8, co4, dn4}, 0);

    // R5 phase two while not armed
    load(8'h35);
    check("R8 load8", acc8, 8'h35);
    check("R8 load4", acc4, 4'h5);
    pulse(ph2);
    @(negedge clk);
    check("R5 acc8", acc8, 8'h35);
    check("R5 done8", dn8, 0);
    check("R5 acc4", acc4, 4'h5);

    // R6 second phase-one strobe ignored
    load(8'h03);
    z8 = 8'h01; z4 = 4'h1;
    pulse(ph1);
    z8 = 8'h06; z4 = 4'h6;
    pulse(ph1);
    check("R6 partial8", acc8, 8'h02);
    resolve(cyc);
    check("R6 sum8", acc8, 8'h04);
    check("R6 sum4", acc4, 4'h4);

    // R9 clear during carry resolution ignored
    load(8'hFF);
    z8 = 8'h01; z4 = 4'h1;
    pulse(ph1);
    ph2 = 1'b1;
    @(negedge clk);
    ph2 = 1'b0;
    pulse(clr);
    repeat (3) @(negedge clk);
    check("R9 sum8", {co8, acc8}, 9'h100);
    check("R9 done8", dn8, 1);

    // R7 priority: clear beats load
    z8 = 8'hAA; z4 = 4'hA;
    clr = 1'b1; ld = 1'b1;
    @(negedge clk);
    clr = 1'b0; ld = 1'b0;
    @(negedge clk);
    check("R7 priority", acc8, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule